// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flag

This block is a 512-word by 18-bit first-in first-out buffer that joins two clock domains. A producer writes words under the load clock and a consumer removes them under the unload clock. The two clocks may be unrelated, or they may be the same clock. The oldest stored word is always presented on the data outputs, so the consumer sees the head of the queue before it asks for it. A read only advances to the next word.

Status is reported by four flags:

- a full flag, active low;
- an empty flag, active low;
- a half-full flag;
- one combined almost flag, which is high near either end of the buffer.

The two thresholds of the almost flag come over the data input. While the program strobe is held low, the first one or two load cycles after reset carry them. If no programming occurs, both thresholds are 32. An output enable releases the data outputs to high impedance.

Each clock domain samples the single synchronous reset. A load cycle means a load-clock rising edge with `wr_en` high. An unload cycle means an unload-clock rising edge with `rd_en` high.

Top module: `xclk_fifo`

## Requirements
- R1: Words leave the buffer in the order they were loaded, with all 18 bits intact. Up to 512 words can be held at once.
- R2: `full_n` is low exactly when 512 words are held. A load cycle while full leaves the stored words and their order unchanged.
- R3: An unload cycle while empty has no effect. The next word loaded afterwards is the next word presented.
- R4: `empty_n` is low exactly when no words are held.
- R5: `half_full` is high when 256 or more words are held, and low at 255 or fewer.
- R6: With `cfg_n` low, the first load cycle after reset takes the low-end offset X from `din[8:0]`. The second such cycle takes the high-end offset Y from `din[8:0]`. Neither of these cycles stores a word.
- R7: `almost` is high when the count is X or less, or when the count is 512 minus Y or more. It is low for counts from X+1 through 511 minus Y.
- R8: If `cfg_n` is high on a load cycle, the programming window closes and that cycle stores a word. Any offset not yet loaded stays at 32.
- R9: The first word loaded into an empty buffer appears on `dout`, and `empty_n` rises, with no unload cycle. This happens within three unload-clock edges.
- R10: While `oe_n` is high, `dout` is high impedance.
- R11: After reset, `full_n` is high, `empty_n` is low, `half_full` is low and `almost` is high.
- R12: Order and contents are preserved when the two clocks run at unrelated frequencies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Load clock |
| rd_clk | input | 1 | Unload clock |
| rst | input | 1 | Synchronous active-high reset, sampled in both domains |
| wr_en | input | 1 | Load request for this load-clock edge |
| cfg_n | input | 1 | Active-low threshold programming strobe |
| din | input | 18 | Data word, or offset in bits 8:0 while programming |
| rd_en | input | 1 | Unload request for this unload-clock edge |
| oe_n | input | 1 | Active-low output enable |
| dout | output | 18 | Head-of-queue word, high impedance when disabled |
| full_n | output | 1 | Low when 512 words are held |
| empty_n | output | 1 | Low when no words are held |
| half_full | output | 1 | High at 256 or more words |
| almost | output | 1 | High near either end of the buffer |

## Verification
A pointer that skips or repeats shows up in two ways. The next word presented on `dout` is out of sequence, and the flags disagree with the count the bench keeps. The bench therefore checks every fill level from 0 to 512 and back down. At each level it waits only the three-edge synchronizer delay before comparing all four flags. A stale synchronizer or a wrong threshold register shows up at the level where the expected flag value changes. Corruption while full shows up as a wrong word during the drain that follows.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;

    // Offset register width; wide enough for any depth used here.
    localparam int OFS_W = 16;

    typedef enum logic [1:0] {
        PRG_LOW_END,
        PRG_HIGH_END,
        PRG_CLOSED
    } prog_state_e;

    typedef struct packed {
        logic [OFS_W-1:0] low_lvl;   // almost-empty offset
        logic [OFS_W-1:0] high_lvl;  // almost-full offset
    } thresh_t;

endpackage

// File: rtl/xclk_fifo_gray_sync.sv
module xclk_fifo_gray_sync #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] meta_q, sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_in;
            sync_q <= meta_q;
        end
    end

    // Gray to binary: each bit is the XOR of itself and all bits above it.
    for (genvar i = 0; i < W; i++) begin : g_dec
        assign bin_out[i] = ^sync_q[W-1:i];
    end
endmodule

// File: rtl/xclk_fifo_wr_ctl.sv
module xclk_fifo_wr_ctl
    import xclk_fifo_pkg::*;
#(
    parameter int AW      = 9,
    parameter int DEF_OFS = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          cfg_n,
    input  logic [AW-1:0] ofs_in,
    input  logic [AW:0]   rd_bin_s,
    output logic          push,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wr_bin,
    output logic [AW:0]   wr_gray,
    output logic [AW:0]   fill,
    output logic          full_n,
    output logic          half_full,
    output logic          near_full,
    output thresh_t       thr
);
    localparam int DEPTH = 1 << AW;
    localparam int HALF  = DEPTH / 2;

    prog_state_e state;
    logic        prog_cyc;
    logic        full;
    logic [AW:0] bin_nxt;

    assign fill      = wr_bin - rd_bin_s;
    assign full      = fill == (AW+1)'(DEPTH);
    assign prog_cyc  = wr_en && !cfg_n && (state != PRG_CLOSED);
    assign push      = wr_en && !prog_cyc && !full;
    assign bin_nxt   = wr_bin + 1'b1;
    assign waddr     = wr_bin[AW-1:0];
    assign full_n    = !full;
    assign half_full = fill >= (AW+1)'(HALF);
    assign near_full = (32'(fill) + 32'(thr.high_lvl)) >= 32'(DEPTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_bin       <= '0;
            wr_gray      <= '0;
            state        <= PRG_LOW_END;
            thr.low_lvl  <= OFS_W'(DEF_OFS);
            thr.high_lvl <= OFS_W'(DEF_OFS);
        end else begin
            if (push) begin
                wr_bin  <= bin_nxt;
                wr_gray <= bin_nxt ^ (bin_nxt >> 1);
            end
            if (wr_en) begin
                unique case (state)
                    PRG_LOW_END: begin
                        if (!cfg_n) begin
                            thr.low_lvl <= OFS_W'(ofs_in);
                            state       <= PRG_HIGH_END;
                        end else begin
                            state <= PRG_CLOSED;
                        end
                    end
                    PRG_HIGH_END: begin
                        if (!cfg_n) thr.high_lvl <= OFS_W'(ofs_in);
                        state <= PRG_CLOSED;
                    end
                    default: state <= PRG_CLOSED;
                endcase
            end
        end
    end
endmodule

// File: rtl/xclk_fifo_rd_ctl.sv
module xclk_fifo_rd_ctl
    import xclk_fifo_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [AW:0]      wr_bin_s,
    input  logic [OFS_W-1:0] low_lvl,
    output logic [AW-1:0]    raddr,
    output logic [AW:0]      rd_bin,
    output logic [AW:0]      rd_gray,
    output logic             empty_n,
    output logic             near_empty
);
    logic [AW:0] fill;
    logic [AW:0] bin_nxt;
    logic        pop;

    assign fill       = wr_bin_s - rd_bin;
    assign empty_n    = fill != '0;
    assign pop        = rd_en && empty_n;
    assign bin_nxt    = rd_bin + 1'b1;
    assign raddr      = rd_bin[AW-1:0];
    // low_lvl is written only in the first load cycles after reset, so it
    // is treated as static configuration in this domain.
    assign near_empty = 32'(fill) <= 32'(low_lvl);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_bin  <= '0;
            rd_gray <= '0;
        end else if (pop) begin
            rd_bin  <= bin_nxt;
            rd_gray <= bin_nxt ^ (bin_nxt >> 1);
        end
    end
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
    import xclk_fifo_pkg::*;
#(
    parameter int DW      = 18,
    parameter int AW      = 9,
    parameter int DEF_OFS = 32
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          cfg_n,
    input  logic [DW-1:0] din,
    input  logic          rd_en,
    input  logic          oe_n,
    output wire  [DW-1:0] dout,
    output logic          full_n,
    output logic          empty_n,
    output logic          half_full,
    output logic          almost
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] head;
    logic [AW-1:0] waddr, raddr;
    logic [AW:0]   wbin, wgray, rbin, rgray, wbin_s, rbin_s, wfill;
    logic          push, near_full, near_empty;
    thresh_t       thr;

    xclk_fifo_wr_ctl #(.AW(AW), .DEF_OFS(DEF_OFS)) u_wr (
        .clk(wr_clk), .rst(rst), .wr_en(wr_en), .cfg_n(cfg_n),
        .ofs_in(din[AW-1:0]), .rd_bin_s(rbin_s), .push(push),
        .waddr(waddr), .wr_bin(wbin), .wr_gray(wgray), .fill(wfill),
        .full_n(full_n), .half_full(half_full), .near_full(near_full),
        .thr(thr)
    );

    xclk_fifo_rd_ctl #(.AW(AW)) u_rd (
        .clk(rd_clk), .rst(rst), .rd_en(rd_en), .wr_bin_s(wbin_s),
        .low_lvl(thr.low_lvl), .raddr(raddr), .rd_bin(rbin),
        .rd_gray(rgray), .empty_n(empty_n), .near_empty(near_empty)
    );

    xclk_fifo_gray_sync #(.W(AW+1)) u_w2r (
        .clk(rd_clk), .rst(rst), .gray_in(wgray), .bin_out(wbin_s)
    );

    xclk_fifo_gray_sync #(.W(AW+1)) u_r2w (
        .clk(wr_clk), .rst(rst), .gray_in(rgray), .bin_out(rbin_s)
    );

    always_ff @(posedge wr_clk) begin
        if (push) mem[waddr] <= din;
    end

    // Fall-through: the head slot is read without waiting for an unload.
    assign head   = mem[raddr];
    assign dout   = oe_n ? {DW{1'bz}} : head;
    assign almost = near_full | near_empty;
endmodule

module xclk_fifo_chk #(
    parameter int DW = 18,
    parameter int AW = 9
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst,
    input logic          wr_en,
    input logic          rd_en,
    input logic          full_n,
    input logic          empty_n,
    input logic [AW:0]   wbin,
    input logic [AW:0]   rbin,
    input logic [AW:0]   wfill,
    input logic [DW-1:0] head
);
    localparam int DEPTH = 1 << AW;

    // R2
    no_write_full_chk: assert property (@(posedge wr_clk) disable iff (rst)
        (wr_en && !full_n) |=> $stable(wbin));
    // R3
    no_read_empty_chk: assert property (@(posedge rd_clk) disable iff (rst)
        (rd_en && !empty_n) |=> $stable(rbin));
    // R2
    no_overflow_chk: assert property (@(posedge wr_clk) disable iff (rst)
        32'(wfill) <= DEPTH);
    // R1
    wr_step_chk: assert property (@(posedge wr_clk) disable iff (rst)
        1'b1 |=> (wbin == $past(wbin) || wbin == $past(wbin) + 1'b1));
    // R9
    head_hold_chk: assert property (@(posedge rd_clk) disable iff (rst)
        (empty_n && !rd_en) |=> $stable(head));
    // R4
    flags_excl_chk: assert property (@(posedge wr_clk) disable iff (rst)
        !(!full_n && !empty_n));
endmodule

bind xclk_fifo xclk_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .wr_en(wr_en),
    .rd_en(rd_en), .full_n(full_n), .empty_n(empty_n), .wbin(wbin),
    .rbin(rbin), .wfill(wfill), .head(head)
);

// File: tb/xclk_fifo_tb.sv
module xclk_fifo_tb;
    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        rst    = 1'b1;
    logic        wr_en  = 1'b0;
    logic        cfg_n  = 1'b1;
    logic [17:0] din    = '0;
    logic        rd_en  = 1'b0;
    logic        oe_n   = 1'b0;
    wire  [17:0] dout;
    logic        full_n, empty_n, half_full, almost;
    int          rd_half = 10;
    int          n_chk = 0;
    int          n_fail = 0;

    always #10 wr_clk = ~wr_clk;
    always #(rd_half) rd_clk = ~rd_clk;

    xclk_fifo u_dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .wr_en(wr_en),
        .cfg_n(cfg_n), .din(din), .rd_en(rd_en), .oe_n(oe_n), .dout(dout),
        .full_n(full_n), .empty_n(empty_n), .half_full(half_full),
        .almost(almost)
    );

    function automatic logic [17:0] word(int i);
        return 18'(i * 37 + 5);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic push(input logic [17:0] d);
        @(negedge wr_clk); wr_en = 1'b1; din = d;
        @(negedge wr_clk); wr_en = 1'b0;
    endtask

    task automatic pop();
        @(negedge rd_clk); rd_en = 1'b1;
        @(negedge rd_clk); rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge wr_clk);
    endtask

    task automatic do_reset();
        @(negedge wr_clk); rst = 1'b1;
        repeat (6) @(negedge wr_clk);
        rst = 1'b0;
    endtask

    // Expected flags from the word count n and the offsets x, y.
    task automatic flags(input int n, input int x, input int y);
        chk("R2 full_n",    32'(full_n),    32'(n != 512));
        chk("R4 empty_n",   32'(empty_n),   32'(n != 0));
        chk("R5 half_full", 32'(half_full), 32'(n >= 256));
        chk("R7 almost",    32'(almost),    32'((n <= x) || (n >= 512 - y)));
    endtask

    task automatic sweep(input int x, input int y);
        for (int n = 1; n <= 512; n++) begin
            push(word(n - 1));
            settle();
            flags(n, x, y);
            if (n == 1) chk("R9 fall-through head", 32'(dout), 32'(word(0)));
        end
        push(~word(0));                     // R2 load while full
        settle();
        flags(512, x, y);
        for (int i = 0; i < 512; i++) begin
            chk("R1 order", 32'(dout), 32'(word(i)));
            pop();
            settle();
            flags(511 - i, x, y);
        end
        pop();                              // R3 unload while empty
        settle();
        flags(0, x, y);
        push(word(600));
        settle();
        chk("R3 head after empty unload", 32'(dout), 32'(word(600)));
        flags(1, x, y);
        pop();
        settle();
    endtask

    initial begin
        do_reset();
        @(negedge wr_clk);
        chk("R11 full_n",    32'(full_n),    32'd1);
        chk("R11 empty_n",   32'(empty_n),   32'd0);
        chk("R11 half_full", 32'(half_full), 32'd0);
        chk("R11 almost",    32'(almost),    32'd1);

        // R6: program X=5, Y=7 with junk in the upper bits
        cfg_n = 1'b0;
        push(18'h3FE05);
        push(18'h3FE07);
        cfg_n = 1'b1;
        settle();
        chk("R6 program cycles store nothing", 32'(empty_n), 32'd0);
        sweep(5, 7);

        // R10
        push(word(9));
        settle();
        oe_n = 1'b1;
        #1;
        chk("R10 high impedance", 32'(dout === 18'bz), 32'd1);
        oe_n = 1'b0;
        #1;
        chk("R10 enabled again", 32'(dout), 32'(word(9)));
        pop();
        settle();

        // R8: no programming, both offsets default to 32
        do_reset();
        sweep(32, 32);

        // R8: only X programmed; the second load stores data
        do_reset();
        cfg_n = 1'b0;
        push(18'h00002);
        cfg_n = 1'b1;
        push(word(7));
        settle();
        chk("R8 data after window", 32'(dout), 32'(word(7)));
        flags(1, 2, 32);
        push(word(8));
        push(word(10));
        settle();
        flags(3, 2, 32);
        repeat (3) pop();
        settle();
        flags(0, 2, 32);

        // R12: unrelated clock rates, concurrent traffic
        rd_half = 17;
        do_reset();
        fork
            begin
                for (int i = 0; i < 60; i++) begin
                    while (!full_n) @(negedge wr_clk);
                    push(word(i + 1000));
                end
            end
            begin
                for (int i = 0; i < 60; i++) begin
                    @(negedge rd_clk);
                    while (!empty_n) @(negedge rd_clk);
                    chk("R12 async order", 32'(dout), 32'(word(i + 1000)));
                    pop();
                end
            end
        join
        repeat (8) @(negedge wr_clk);
        chk("R12 drained", 32'(empty_n), 32'd0);

        summary();
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog act=running exp=done");
        summary();
        $finish;
    end
endmodule